// File: doc/BRIEF.md
# Ring Serial Bus Member Node

This block is a single member station on a unidirectional ring bus that uses two signal lines, a clock and a data line. Each station has one input and one output for each line. A mediator elsewhere on the ring generates the bus clock. A member that has nothing to do passes both lines straight through to the next station. A member that wants to send pulls its data output low while the bus is idle. It wins arbitration if it is the first requester downstream of the mediator. It then serialises an address byte and its payload bytes.

Every station watches the incoming address. It accepts a short address when the 4-bit prefix matches its current class prefix or the broadcast prefix. It accepts a full address when its 24-bit device identity matches. It delivers payload bytes on a local receive strobe. A transaction ends with an interjection, in which the clock is held high while the data line toggles. A two-bit control phase follows, and in it the addressed receiver acknowledges the whole transaction once. The station runs on a local clock that oversamples both bus lines. The bus clock and data are assumed to be synchronous to that local clock.

Top module: `rsb_member`

## Requirements
- R1: `clk_out` always equals `clk_in`. `data_out` equals `data_in` whenever the node has no pending request, has not won the bus, and is not acknowledging. After reset `data_out` is 1 and no strobe output is active.
- R2: A pulse on `tx_req` in idle latches `tx_addr` and makes the request pending. While a request is pending in idle or arbitration, `data_out` is 0. A node that samples `data_in` = 0 at the first rising bus-clock edge of a transaction loses. It forwards data for the rest of that transaction and requests again in the next idle period.
- R3: A node that samples `data_in` = 1 at that edge wins. On each later falling bus-clock edge it presents one bit on `data_out`: first the 8 bits of `tx_addr` MSB first, then each payload byte MSB first. `tx_take` pulses once for each payload byte it loads from `tx_data`. The byte loaded while `tx_last` is 1 is the final one, and after it `data_out` stays 1.
- R4: A short address is 8 bits, a prefix in bits 7:4 and a function code in bits 3:0. It is accepted when the prefix equals the node's current class prefix, and `rx_func` then takes the function code.
- R5: A prefix of 4'hF announces a full address of 32 bits: 4'hF, a 24-bit device identity, then a 4-bit function code. It is accepted when the identity equals `DEVICE_ID`.
- R6: A message whose address is not accepted produces no `rx_valid` and no `rx_end`, and the node forwards `data_in` through the control phase.
- R7: Prefix 4'h0 is broadcast. Every node accepts it and sets `rx_bcast`, and none drives the control phase.
- R8: Payload bits sampled on rising bus-clock edges are assembled MSB first. Every eighth bit of an accepted message gives a one-cycle `rx_valid` with the byte on `rx_byte`.
- R9: During the address or payload phase, three data edges while the bus clock stays high end the phase. The node then stops driving data and enters the two-bit control phase.
- R10: In the control phase the first bit, the error flag, is forwarded. For the second bit an addressed, non-broadcast receiver drives 1 (ACK) if the payload ended on a byte boundary and 0 (NAK) otherwise. `rx_end` pulses after the second bit for every accepted message.
- R11: After the second control bit a winning node pulses `tx_done` and sets `tx_ack` to 1 exactly when the error bit was 0 and the second bit was 1. Its request is then cleared.
- R12: The class prefix resets to `CLASS_PREFIX`. A `set_prefix_valid` pulse replaces it with `set_prefix`, except that the values 4'h0 and 4'hF are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_in | input | 1 | Bus clock from the upstream station |
| data_in | input | 1 | Bus data from the upstream station |
| clk_out | output | 1 | Bus clock to the downstream station |
| data_out | output | 1 | Bus data to the downstream station |
| set_prefix_valid | input | 1 | Strobe to load a runtime class prefix |
| set_prefix | input | 4 | Runtime class prefix value |
| tx_req | input | 1 | Pulse requesting a transmission |
| tx_addr | input | 8 | Short destination address, sampled with tx_req |
| tx_data | input | 8 | Next payload byte to send |
| tx_last | input | 1 | The byte on tx_data is the final one |
| tx_take | output | 1 | Pulse: tx_data was consumed |
| tx_done | output | 1 | Pulse: own transmission finished |
| tx_ack | output | 1 | Result of the finished transmission |
| rx_valid | output | 1 | Pulse: rx_byte holds a received byte |
| rx_byte | output | 8 | Received payload byte |
| rx_func | output | 4 | Function code of the accepted address |
| rx_bcast | output | 1 | Current message is a broadcast |
| rx_end | output | 1 | Pulse: accepted message completed |

## Verification
Most internal faults show up on `data_out` within one bus bit. A wrong transmit shift state corrupts the serial bit sampled in the same low phase. A lost arbitration decision shows as driven bits where forwarded ones are expected. A stuck control index shows in the acknowledge bit of the same transaction. A wrong address-match state cannot be seen until the first payload byte completes. At that point it appears as a missing or extra `rx_valid` eight bus bits after the address, and as an `rx_end` and acknowledge mismatch at the end of the transaction.

// File: rtl/rsb_pkg.sv
// Shared types and widths for the ring serial bus member.
package rsb_pkg;
    localparam int SHORT_W = 4;
    localparam int FUNC_W  = 4;
    localparam int ID_W    = 24;
    localparam int BYTE_W  = 8;
    localparam int SHORT_ADDR_BITS = SHORT_W + FUNC_W;
    localparam int FULL_ADDR_BITS  = SHORT_W + ID_W + FUNC_W;
    localparam logic [SHORT_W-1:0] FULL_MARK = '1;
    localparam logic [SHORT_W-1:0] BCAST_PFX = '0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_ADDR,
        ST_DATA,
        ST_CTRL
    } rsb_state_e;
endpackage

// File: rtl/rsb_line_watch.sv
// Line watcher: finds bus-clock edges by oversampling and counts data edges
// seen while the bus clock stays high (interjection).
// Assumes clk_in/data_in are synchronous to clk; idle bus level is 1.
module rsb_line_watch #(
    parameter int EDGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_in,
    input  logic data_in,
    input  logic count_en,
    output logic rise,
    output logic fall,
    output logic intj
);
    localparam int CW = $clog2(EDGES + 1);

    logic          clk_q;
    logic          dat_q;
    logic [CW-1:0] cnt;
    logic          dedge;

    // Previous-sample registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= 1'b1;
            dat_q <= 1'b1;
        end else begin
            clk_q <= clk_in;
            dat_q <= data_in;
        end
    end

    assign rise  = clk_in & ~clk_q;
    assign fall  = ~clk_in & clk_q;
    assign dedge = clk_in & clk_q & (data_in ^ dat_q);
    assign intj  = count_en & dedge & (cnt == CW'(EDGES - 1));

    // Count data edges during one high phase of the bus clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !count_en || !clk_in) begin
            cnt <= '0;
        end else if (dedge && cnt != CW'(EDGES)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rsb_addr_decode.sv
// Address decoder: shifts address bits, decides short or full form and
// reports acceptance when the last address bit arrives.
// Assumes clear is held while not in the address phase.
module rsb_addr_decode
    import rsb_pkg::*;
#(
    parameter logic [ID_W-1:0] DEV_ID = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               shift,
    input  logic               bit_in,
    input  logic [SHORT_W-1:0] short_pfx,
    output logic               done,
    output logic               hit,
    output logic               bcast,
    output logic [FUNC_W-1:0]  func
);
    localparam int CNT_W = $clog2(FULL_ADDR_BITS);

    logic [FULL_ADDR_BITS-1:0] sr;
    logic [FULL_ADDR_BITS-1:0] nxt;
    logic [CNT_W-1:0]          cnt;
    logic [SHORT_W-1:0]        pfx;
    logic                      short_end;
    logic                      full_end;

    assign nxt = {sr[FULL_ADDR_BITS-2:0], bit_in};
    assign pfx = nxt[SHORT_ADDR_BITS-1 -: SHORT_W];

    // Decide end of address and acceptance from the incoming bit.
    always_comb begin
        short_end = shift && (cnt == CNT_W'(SHORT_ADDR_BITS - 1)) && (pfx != FULL_MARK);
        full_end  = shift && (cnt == CNT_W'(FULL_ADDR_BITS - 1));
        done      = short_end || full_end;
        func      = nxt[FUNC_W-1:0];
        bcast     = short_end && (pfx == BCAST_PFX);
        if (short_end) begin
            hit = (pfx == short_pfx) || (pfx == BCAST_PFX);
        end else begin
            hit = full_end && (nxt[FULL_ADDR_BITS-SHORT_W-1 -: ID_W] == DEV_ID);
        end
    end

    // Address shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr  <= '0;
            cnt <= '0;
        end else if (shift) begin
            sr  <= nxt;
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rsb_rx_bytes.sv
// Payload assembler: collects bits MSB first into bytes.
// Assumes clear is held outside the payload phase.
module rsb_rx_bytes
    import rsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              bit_in,
    output logic              done,
    output logic [BYTE_W-1:0] octet,
    output logic              partial
);
    localparam int BW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sr;
    logic [BW-1:0]     idx;

    assign octet   = {sr[BYTE_W-2:0], bit_in};
    assign done    = shift && (idx == BW'(BYTE_W - 1));
    assign partial = (idx != '0);

    // Shift register and bit index within the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr  <= '0;
            idx <= '0;
        end else if (shift) begin
            sr  <= octet;
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/rsb_tx_serial.sv
// Transmit serialiser: after load, emits the address byte and then
// payload bytes MSB first, one bit per step; idles at 1 when exhausted.
// Assumes next_byte/next_last are valid whenever a byte boundary is reached.
module rsb_tx_serial
    import rsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] first,
    input  logic              step,
    input  logic [BYTE_W-1:0] next_byte,
    input  logic              next_last,
    output logic              bit_o,
    output logic              take_o
);
    localparam int BW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sr;
    logic [BW-1:0]     idx;
    logic              more;
    logic              live;

    // Bit output, byte reload and end-of-message tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr     <= '0;
            idx    <= '0;
            more   <= 1'b0;
            live   <= 1'b0;
            bit_o  <= 1'b1;
            take_o <= 1'b0;
        end else begin
            take_o <= 1'b0;
            if (load) begin
                sr    <= first;
                idx   <= '0;
                more  <= 1'b1;
                live  <= 1'b1;
                bit_o <= 1'b1;
            end else if (step) begin
                bit_o <= live ? sr[BYTE_W-1] : 1'b1;
                sr    <= {sr[BYTE_W-2:0], 1'b0};
                idx   <= idx + 1'b1;
                if (idx == BW'(BYTE_W - 1)) begin
                    if (live && more) begin
                        sr     <= next_byte;
                        more   <= !next_last;
                        take_o <= 1'b1;
                    end else begin
                        live <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rsb_member.sv
// Ring bus member: forwards clock and data, arbitrates for its own
// messages, decodes addresses, receives payload and takes part in the
// interjection and two-bit control phase.
// Assumes bus lines are synchronous to clk and each bus half period
// spans at least two clk cycles.
module rsb_member
    import rsb_pkg::*;
#(
    parameter logic [SHORT_W-1:0] CLASS_PREFIX = 4'h5,
    parameter logic [ID_W-1:0]    DEVICE_ID    = 24'hA1B2C3,
    parameter int                 INTJ_EDGES   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_in,
    input  logic              data_in,
    output logic              clk_out,
    output logic              data_out,
    input  logic              set_prefix_valid,
    input  logic [SHORT_W-1:0] set_prefix,
    input  logic              tx_req,
    input  logic [BYTE_W-1:0] tx_addr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_last,
    output logic              tx_take,
    output logic              tx_done,
    output logic              tx_ack,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [FUNC_W-1:0] rx_func,
    output logic              rx_bcast,
    output logic              rx_end
);
    rsb_state_e         state;
    logic [SHORT_W-1:0] short_pfx;
    logic [BYTE_W-1:0]  addr_q;
    logic               pend, won, hit, ack_val, cidx, err_bit;
    logic               rise, fall, intj, in_msg;
    logic               a_done, a_hit, a_bcast;
    logic [FUNC_W-1:0]  a_func;
    logic               b_done, b_partial;
    logic [BYTE_W-1:0]  b_octet;
    logic               tx_bit;

    assign in_msg  = (state == ST_ADDR) || (state == ST_DATA);
    assign clk_out = clk_in;

    rsb_line_watch #(.EDGES(INTJ_EDGES)) u_watch (
        .clk(clk), .rst_n(rst_n), .clk_in(clk_in), .data_in(data_in),
        .count_en(in_msg), .rise(rise), .fall(fall), .intj(intj)
    );

    rsb_addr_decode #(.DEV_ID(DEVICE_ID)) u_addr (
        .clk(clk), .rst_n(rst_n), .clear(state != ST_ADDR),
        .shift(rise && state == ST_ADDR), .bit_in(data_in),
        .short_pfx(short_pfx), .done(a_done), .hit(a_hit),
        .bcast(a_bcast), .func(a_func)
    );

    rsb_rx_bytes u_rx (
        .clk(clk), .rst_n(rst_n), .clear(state != ST_DATA),
        .shift(rise && state == ST_DATA && hit), .bit_in(data_in),
        .done(b_done), .octet(b_octet), .partial(b_partial)
    );

    rsb_tx_serial u_tx (
        .clk(clk), .rst_n(rst_n),
        .load(rise && state == ST_ARB && pend && data_in), .first(addr_q),
        .step(fall && won && in_msg), .next_byte(tx_data),
        .next_last(tx_last), .bit_o(tx_bit), .take_o(tx_take)
    );

    // Transaction sequencing, prefix register and local strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            short_pfx <= CLASS_PREFIX;
            addr_q    <= '0;
            pend      <= 1'b0;
            won       <= 1'b0;
            hit       <= 1'b0;
            rx_bcast  <= 1'b0;
            rx_func   <= '0;
            ack_val   <= 1'b0;
            cidx      <= 1'b0;
            err_bit   <= 1'b0;
            rx_valid  <= 1'b0;
            rx_byte   <= '0;
            rx_end    <= 1'b0;
            tx_done   <= 1'b0;
            tx_ack    <= 1'b0;
        end else begin
            rx_end   <= 1'b0;
            tx_done  <= 1'b0;
            rx_valid <= b_done;
            if (b_done) begin
                rx_byte <= b_octet;
            end
            if (set_prefix_valid && set_prefix != BCAST_PFX && set_prefix != FULL_MARK) begin
                short_pfx <= set_prefix;
            end
            case (state)
                ST_IDLE: begin
                    if (tx_req && !pend) begin
                        pend   <= 1'b1;
                        addr_q <= tx_addr;
                    end
                    if (fall) begin
                        state    <= ST_ARB;
                        won      <= 1'b0;
                        hit      <= 1'b0;
                        rx_bcast <= 1'b0;
                    end
                end
                ST_ARB: begin
                    if (rise) begin
                        state <= ST_ADDR;
                        won   <= pend && data_in;
                    end
                end
                ST_ADDR: begin
                    if (intj) begin
                        state   <= ST_CTRL;
                        ack_val <= 1'b0;
                        cidx    <= 1'b0;
                    end else if (a_done) begin
                        state    <= ST_DATA;
                        hit      <= a_hit && !won;
                        rx_bcast <= a_bcast && !won;
                        if (a_hit && !won) begin
                            rx_func <= a_func;
                        end
                    end
                end
                ST_DATA: begin
                    if (intj) begin
                        state   <= ST_CTRL;
                        ack_val <= !b_partial;
                        cidx    <= 1'b0;
                    end
                end
                ST_CTRL: begin
                    if (rise) begin
                        if (!cidx) begin
                            cidx    <= 1'b1;
                            err_bit <= data_in;
                        end else begin
                            state  <= ST_IDLE;
                            rx_end <= hit;
                            if (won) begin
                                tx_done <= 1'b1;
                                tx_ack  <= !err_bit && data_in;
                                pend    <= 1'b0;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output data selection: request pull-down, own bits, acknowledge, or forward.
    always_comb begin
        data_out = data_in;
        case (state)
            ST_IDLE, ST_ARB: if (pend) data_out = 1'b0;
            ST_ADDR, ST_DATA: if (won) data_out = tx_bit;
            ST_CTRL: if (hit && !rx_bcast && cidx) data_out = ack_val;
            default: data_out = data_in;
        endcase
    end
endmodule

// File: rtl/rsb_member_chk.sv
// Property checker for rsb_member, attached by bind.
// Assumes it observes the member's ports and a few state decodes.
module rsb_member_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_idle,
    input logic       in_ctrl,
    input logic       pend,
    input logic       won,
    input logic       hit,
    input logic       bcast,
    input logic       data_in,
    input logic       data_out,
    input logic       rx_valid,
    input logic       rx_end,
    input logic       tx_take,
    input logic       tx_done,
    input logic       set_prefix_valid,
    input logic [3:0] set_prefix,
    input logic [3:0] short_pfx
);
    // R2
    req_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && pend) |-> !data_out);
    // R7
    bcast_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ctrl && bcast) |-> (data_out == data_in));
    // R6
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ctrl && !hit) |-> (data_out == data_in));
    // R8
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R12
    pfx_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_prefix_valid && (set_prefix == 4'h0 || set_prefix == 4'hF)) |=> $stable(short_pfx));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);
    // R10
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_end |-> in_idle);
    // R3
    take_won_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> won);
endmodule

bind rsb_member rsb_member_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_idle(state == ST_IDLE), .in_ctrl(state == ST_CTRL),
    .pend(pend), .won(won), .hit(hit), .bcast(rx_bcast),
    .data_in(data_in), .data_out(data_out),
    .rx_valid(rx_valid), .rx_end(rx_end), .tx_take(tx_take), .tx_done(tx_done),
    .set_prefix_valid(set_prefix_valid), .set_prefix(set_prefix),
    .short_pfx(short_pfx)
);

// File: tb/tb_rsb_member.sv
`timescale 1ns/1ps
module tb_rsb_member;
    localparam logic [3:0]  CLS = 4'h5;
    localparam logic [23:0] DID = 24'hA1B2C3;
    localparam int H = 4;

    logic clk = 0, rst_n = 0, clk_in = 1, data_in = 1;
    logic clk_out, data_out, set_prefix_valid = 0, tx_req = 0;
    logic [3:0] set_prefix = 0, rx_func;
    logic [7:0] tx_addr = 0, tx_data, rx_byte;
    logic tx_last, tx_take, tx_done, tx_ack, rx_valid, rx_bcast, rx_end;
    logic [7:0] txb [8];
    int tidx = 0, tn = 1;
    int checks = 0, fails = 0, n_end = 0, n_take = 0, n_done = 0;
    logic last_ack = 0;
    logic [7:0] rxq [$];
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign tx_data = txb[tidx[2:0]];
    assign tx_last = (tidx == tn - 1);

    rsb_member #(.CLASS_PREFIX(CLS), .DEVICE_ID(DID), .INTJ_EDGES(3)) dut (
        .clk(clk), .rst_n(rst_n), .clk_in(clk_in), .data_in(data_in),
        .clk_out(clk_out), .data_out(data_out),
        .set_prefix_valid(set_prefix_valid), .set_prefix(set_prefix),
        .tx_req(tx_req), .tx_addr(tx_addr), .tx_data(tx_data), .tx_last(tx_last),
        .tx_take(tx_take), .tx_done(tx_done), .tx_ack(tx_ack),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_func(rx_func),
        .rx_bcast(rx_bcast), .rx_end(rx_end)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) rxq.push_back(rx_byte);
        if (rx_end) n_end++;
        if (tx_take) begin n_take++; tidx++; end
        if (tx_done) begin n_done++; last_ack = tx_ack; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic d, output logic seen);
        clk_in = 0; data_in = d;
        wait_n(H);
        seen = data_out;
        clk_in = 1;
        wait_n(H);
    endtask

    function automatic void push_byte(ref logic q[$], input logic [7:0] b);
        for (int i = 7; i >= 0; i--) q.push_back(b[i]);
    endfunction

    // Mediator: arbitration bit, given bits, interjection, two control bits.
    task automatic run_txn(input logic arb, input logic bits[$], input logic err,
                           input logic ctl1, output logic seen[$],
                           output logic c0, output logic c1);
        logic s;
        seen.delete();
        rxq.delete();
        n_end = 0;
        bus_bit(arb, s);
        foreach (bits[i]) begin
            bus_bit(bits[i], s);
            seen.push_back(s);
        end
        for (int t = 0; t < 6; t++) begin
            data_in = ~data_in;
            wait_n(H);
        end
        bus_bit(err, c0);
        bus_bit(ctl1, c1);
        data_in = 1;
        wait_n(2 * H);
    endtask

    // Receive a message with given address bits and bytes; check delivery.
    task automatic rx_case(input logic abits[$], input int nb, input bit expect_hit,
                           input logic [3:0] fn, input bit is_bc, input string req);
        logic bits[$], seen[$], c0, c1;
        logic [7:0] pay [4];
        int bad;
        bits = abits;
        for (int i = 0; i < nb; i++) begin
            pay[i] = 8'($urandom);
            push_byte(bits, pay[i]);
        end
        run_txn(1'b1, bits, 1'b0, 1'b0, seen, c0, c1);
        bad = 0;
        foreach (bits[i]) if (seen[i] !== bits[i]) bad++;
        chk(bad == 0, {req, " forwarding"}, bad, 0);
        if (expect_hit) begin
            bad = (rxq.size() != nb);
            for (int i = 0; i < nb && i < rxq.size(); i++) if (rxq[i] !== pay[i]) bad++;
            chk(bad == 0, {req, " R8 bytes"}, rxq.size(), nb);
            chk(rx_func == fn, {req, " func"}, rx_func, fn);
            chk(n_end == 1, {req, " R10 rx_end"}, n_end, 1);
            chk(rx_bcast == is_bc, {req, " bcast flag"}, rx_bcast, is_bc);
            chk(c1 == (is_bc ? 1'b0 : 1'b1), {req, " R10 ack bit"}, c1, !is_bc);
        end else begin
            chk(rxq.size() == 0 && n_end == 0, {req, " R6 silent"}, rxq.size() + n_end, 0);
            chk(c1 == 1'b0, {req, " R6 ctrl forwarded"}, c1, 0);
        end
    endtask

    function automatic void short_addr(ref logic q[$], input logic [3:0] p, input logic [3:0] f);
        q.delete();
        push_byte(q, {p, f});
    endfunction

    task automatic set_pfx(input logic [3:0] v);
        set_prefix = v; set_prefix_valid = 1;
        wait_n(1);
        set_prefix_valid = 0;
        wait_n(1);
    endtask

    // Own transmission; arb selects win or loss, err the error bit.
    task automatic tx_case(input logic arb, input logic err, input int nb, input string req);
        logic bits[$], seen[$], exp[$], c0, c1;
        logic [7:0] a;
        int bad, d0;
        a = 8'($urandom);
        tn = nb; tidx = 0; n_take = 0; n_done = 0;
        for (int i = 0; i < nb; i++) txb[i] = 8'($urandom);
        tx_addr = a; tx_req = 1;
        wait_n(1);
        tx_req = 0;
        wait_n(2);
        chk(data_out == 1'b0 && data_in == 1'b1, {req, " R2 request pull"}, data_out, 0);
        exp.delete();
        push_byte(exp, a);
        for (int i = 0; i < nb; i++) push_byte(exp, txb[i]);
        for (int i = 0; i < 3; i++) exp.push_back(1'b1);
        bits.delete();
        for (int i = 0; i < exp.size(); i++) bits.push_back(1'($urandom));
        run_txn(arb, bits, err, 1'b1, seen, c0, c1);
        bad = 0;
        if (arb) begin
            foreach (exp[i]) if (seen[i] !== exp[i]) bad++;
            chk(bad == 0, {req, " R3 serial bits"}, bad, 0);
            chk(n_take == nb, {req, " R3 take count"}, n_take, nb);
            chk(c0 == err, {req, " R9 released after interjection"}, c0, err);
            chk(n_done == 1, {req, " R11 done"}, n_done, 1);
            chk(last_ack == !err, {req, " R11 ack"}, last_ack, !err);
        end else begin
            foreach (bits[i]) if (seen[i] !== bits[i]) bad++;
            chk(bad == 0, {req, " R2 loser forwards"}, bad, 0);
            chk(n_done == 0, {req, " R2 no done"}, n_done, 0);
            d0 = data_out;
            chk(d0 == 0, {req, " R2 retry request"}, d0, 0);
        end
    endtask

    initial begin
        logic ab[$];
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) txb[i] = 0;
        wait_n(4);
        rst_n = 1;
        wait_n(2);
        // R1: reset state and shoot-through
        chk(data_out == 1 && clk_out == clk_in, "R1 reset lines", data_out, 1);
        chk(!rx_valid && !tx_take && !tx_done && !rx_end, "R1 reset strobes", rx_valid, 0);

        // R6: foreign short prefix
        short_addr(ab, 4'h3, 4'h2);
        rx_case(ab, 2, 0, 0, 0, "R6 short mismatch");

        // R4 R8 R10: random short matches
        for (int k = 0; k < 4; k++) begin
            logic [3:0] f;
            f = 4'($urandom);
            short_addr(ab, CLS, f);
            rx_case(ab, 1 + int'($urandom % 4), 1, f, 0, "R4 short match");
        end

        // R10: partial byte gives NAK
        begin
            logic bits[$], seen[$], c0, c1;
            short_addr(bits, CLS, 4'h7);
            push_byte(bits, 8'hA5);
            bits.push_back(1); bits.push_back(0); bits.push_back(1);
            run_txn(1'b1, bits, 1'b0, 1'b1, seen, c0, c1);
            chk(rxq.size() == 1, "R10 partial bytes", rxq.size(), 1);
            chk(c1 == 1'b0, "R10 partial NAK", c1, 0);
        end

        // R5: full address match and mismatch
        ab.delete();
        push_byte(ab, {4'hF, DID[23:20]});
        push_byte(ab, DID[19:12]);
        push_byte(ab, DID[11:4]);
        push_byte(ab, {DID[3:0], 4'hC});
        rx_case(ab, 3, 1, 4'hC, 0, "R5 full match");
        ab.delete();
        push_byte(ab, {4'hF, DID[23:20]});
        push_byte(ab, DID[19:12]);
        push_byte(ab, DID[11:4]);
        push_byte(ab, {DID[3:0] ^ 4'h1, 4'hC});
        rx_case(ab, 1, 0, 0, 0, "R6 full mismatch");

        // R7: broadcast
        short_addr(ab, 4'h0, 4'h9);
        rx_case(ab, 2, 1, 4'h9, 1, "R7 broadcast");

        // R12: reserved values ignored, then a new prefix
        set_pfx(4'h0);
        set_pfx(4'hF);
        short_addr(ab, CLS, 4'h1);
        rx_case(ab, 1, 1, 4'h1, 0, "R12 reserved ignored");
        set_pfx(4'h9);
        short_addr(ab, 4'h9, 4'h4);
        rx_case(ab, 2, 1, 4'h4, 0, "R12 new prefix");
        short_addr(ab, CLS, 4'h4);
        rx_case(ab, 1, 0, 0, 0, "R12 old prefix gone");

        // R3 R11: wins, with and without error flag
        tx_case(1'b1, 1'b0, 2, "R3 win");
        tx_case(1'b1, 1'b1, 3, "R11 win error");
        // R2: lose arbitration, then win on the retry
        tx_case(1'b0, 1'b0, 1, "R2 lose");
        begin
            logic bits[$], seen[$], c0, c1;
            for (int i = 0; i < 19; i++) bits.push_back(1'b1);
            n_done = 0;
            run_txn(1'b1, bits, 1'b0, 1'b1, seen, c0, c1);
            chk(n_done == 1, "R2 retry completes", n_done, 1);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule